// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one performance-monitoring counter. Each clock it is given the number of occurrences of a monitored event in that clock, an 8-bit vector of sub-qualifiers for the event, and the current 2-bit privilege level. A 32-bit control register decides whether the clock contributes to a 48-bit accumulator and by how much. The decision applies, in order, privilege gating, sub-qualifier masking, a threshold compare that can be inverted, and an optional rising-edge filter.

The counter drives a monitor pin and a sticky interrupt request. In one mode the pin pulses for every cycle that adds to the counter. In the other it pulses only when the accumulator wraps. The interrupt request is raised on a wrap when enabled. Software clears it by writing a 1.

Software reaches the control register, both halves of the counter and the interrupt flag through a small register port. Reads are combinational. Writes take effect at the next clock edge.

Top module: `qec_counter`

## Requirements
- R1: After reset the control register, the counter and the interrupt flag read zero, and the monitor pin and the interrupt request are low.
- R2: Control bit 17 permits counting at privilege level 0 and bit 16 permits counting at levels 1 to 3. A clock at a level whose bit is clear adds nothing.
- R3: When control bits 15:8 (the sub-qualifier mask) are zero, every event qualifies. When they are non-zero, a clock qualifies only if the mask and the sub-qualifier input share at least one set bit.
- R4: With the threshold (control bits 31:24) at zero and edge mode off, a qualifying clock adds its full event count. Bit 23 then has no effect.
- R5: With a non-zero threshold, a qualifying clock adds exactly 1 when its event count is at least the threshold. When bit 23 is set, it adds 1 when the count is below the threshold instead.
- R6: When control bit 18 is set, the counter adds 1 only in a clock where the condition of R2 to R5 is true and was false in the previous clock. A run of consecutive true clocks adds 1 in total.
- R7: When control bit 22 is clear, the counter does not change except by a software write, and neither the pin nor the interrupt is raised.
- R8: With control bit 19 clear, the monitor pin is high in the clock after each clock that added to the counter, and low otherwise.
- R9: With control bit 19 set, the monitor pin is high only in the clock after the counter wrapped.
- R10: The counter is 48 bits wide and wraps modulo 2^48. A wrap is a carry out of bit 47 caused by an addition.
- R11: With control bit 20 set, a wrap sets the interrupt flag, which stays set until software writes 1 to status bit 0. A wrap in the same clock wins over the clear.
- R12: Register map: address 0 is the control register, with all 32 bits readable as written, including the event select bits 7:0 and bit 21, which have no effect. Address 1 holds counter bits 31:0. Address 2 holds counter bits 47:32 in bits 15:0, with the upper bits reading zero. Address 3 holds the interrupt flag in bit 0. A counter write replaces that clock's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| evt_count | input | 4 | Event occurrences in this clock |
| evt_qual | input | 8 | Event sub-qualifier vector |
| priv_lvl | input | 2 | Current privilege level |
| mon_pin | output | 1 | Monitor pulse output |
| irq_req | output | 1 | Sticky overflow interrupt request |

## Verification
Random control words are drawn with small thresholds so that both sides of the compare are hit often. The event count, the qualifier vector and the privilege level are drawn every clock. This separates full-count accumulation from +1 threshold counting and separates inverted from plain compares, and it exposes wrong mask or privilege gating as count mismatches. Edge mode is tried with long runs of true clocks and with alternating patterns, which tells one-per-run counting apart from level counting. Counter preloads just below 2^48 drive wraps in both pin modes and with the interrupt on and off. This separates the event pulse from the overflow pulse and checks that the flag stays set until a write-1 clear.

// File: rtl/qec_pkg.sv
package qec_pkg;

  typedef struct packed {
    logic [7:0] thresh;     // 31:24
    logic       cmp_inv;    // 23
    logic       enable;     // 22
    logic       spare21;    // 21, no effect
    logic       irq_en;     // 20
    logic       pin_on_ovf; // 19
    logic       edge_mode;  // 18
    logic       allow_kern; // 17
    logic       allow_user; // 16
    logic [7:0] sub_mask;   // 15:8
    logic [7:0] evt_sel;    // 7:0, no effect
  } ctl_t;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_CLO  = 2'd1;
  localparam logic [1:0] ADDR_CHI  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic logic priv_allows(ctl_t c, logic [1:0] lvl);
    return (lvl == 2'd0) ? c.allow_kern : c.allow_user;
  endfunction

  function automatic logic mask_allows(logic [7:0] mask, logic [7:0] qual);
    return (mask == 8'd0) || ((mask & qual) != 8'd0);
  endfunction

  function automatic logic thresh_hit(logic [7:0] n, logic [7:0] t, logic inv);
    return inv ? (n < t) : (n >= t);
  endfunction

endpackage

// File: rtl/qec_qualify.sv
module qec_qualify
  import qec_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  ctl_t             ctl,
  input  logic [EVT_W-1:0] evt_count,
  input  logic [7:0]       evt_qual,
  input  logic [1:0]       priv_lvl,
  output logic             level_hit,
  output logic [EVT_W-1:0] level_amt
);
  logic       gate_ok;
  logic [7:0] cnt_ext;

  always_comb begin
    cnt_ext = 8'(evt_count);
    gate_ok = ctl.enable && priv_allows(ctl, priv_lvl) && mask_allows(ctl.sub_mask, evt_qual);
    if (ctl.thresh != 8'd0)
      level_hit = gate_ok && thresh_hit(cnt_ext, ctl.thresh, ctl.cmp_inv);
    else
      level_hit = gate_ok && (evt_count != '0);
    if (!level_hit)
      level_amt = '0;
    else if (ctl.thresh != 8'd0)
      level_amt = EVT_W'(1);
    else
      level_amt = evt_count;
  end
endmodule

// File: rtl/qec_step.sv
module qec_step #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_mode,
  input  logic             level_hit,
  input  logic [EVT_W-1:0] level_amt,
  output logic [EVT_W-1:0] step_amt
);
  logic hit_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_prev <= 1'b0;
    else        hit_prev <= level_hit;
  end

  always_comb begin
    if (edge_mode) step_amt = (level_hit && !hit_prev) ? EVT_W'(1) : '0;
    else           step_amt = level_amt;
  end
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] step_amt,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             counted,
  output logic             ovf
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W:0] sum;
  logic           wr_any;

  always_comb begin
    wr_any  = wr_lo || wr_hi;
    sum     = {1'b0, cnt_q} + (CNT_W+1)'(step_amt);
    counted = (step_amt != '0) && !wr_any;
    ovf     = sum[CNT_W] && !wr_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo) cnt_q[31:0]      <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:32] <= wdata[HI_W-1:0];
    end else begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/qec_counter.sv
module qec_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EVT_W-1:0] evt_count,
  input  logic [7:0]       evt_qual,
  input  logic [1:0]       priv_lvl,
  output logic             mon_pin,
  output logic             irq_req
);
  localparam int HI_W = CNT_W - 32;

  ctl_t             ctl;
  logic             level_hit;
  logic [EVT_W-1:0] level_amt;
  logic [EVT_W-1:0] step_amt;
  logic [CNT_W-1:0] cnt_q;
  logic             counted;
  logic             ovf;
  logic             cnt_wr;
  logic             irq_clr;
  logic             wr_lo;
  logic             wr_hi;

  assign wr_lo   = reg_wr && (reg_addr == ADDR_CLO);
  assign wr_hi   = reg_wr && (reg_addr == ADDR_CHI);
  assign cnt_wr  = wr_lo || wr_hi;
  assign irq_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

  qec_qualify #(.EVT_W(EVT_W)) u_qual (
    .ctl(ctl), .evt_count(evt_count), .evt_qual(evt_qual), .priv_lvl(priv_lvl),
    .level_hit(level_hit), .level_amt(level_amt)
  );

  qec_step #(.EVT_W(EVT_W)) u_step (
    .clk(clk), .rst_n(rst_n), .edge_mode(ctl.edge_mode),
    .level_hit(level_hit), .level_amt(level_amt), .step_amt(step_amt)
  );

  qec_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step_amt(step_amt), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(reg_wdata), .cnt_q(cnt_q), .counted(counted), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      mon_pin <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == ADDR_CTL)) ctl <= ctl_t'(reg_wdata);
      mon_pin <= ctl.pin_on_ovf ? ovf : counted;
      if (ctl.irq_en && ovf) irq_req <= 1'b1;
      else if (irq_clr)      irq_req <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTL:  reg_rdata = ctl;
      ADDR_CLO:  reg_rdata = cnt_q[31:0];
      ADDR_CHI:  reg_rdata = 32'(cnt_q[CNT_W-1:32]);
      default:   reg_rdata = {31'd0, irq_req};
    endcase
  end
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctl_bits,
  input logic [EVT_W-1:0] step_amt,
  input logic             counted,
  input logic             ovf,
  input logic             cnt_wr,
  input logic             irq_clr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mon_pin,
  input logic             irq_req
);
  AST_THRESH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[31:24] != 8'd0) |-> (step_amt <= EVT_W'(1)));                        // R5
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[18] |-> (step_amt <= EVT_W'(1)));                                      // R6
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_bits[22] && !cnt_wr) |=> $stable(cnt_q));                                 // R7
  AST_PIN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_bits[19] && counted) |=> mon_pin);                                        // R8
  AST_PIN_OVF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[19] && !ovf) |=> !mon_pin);                                           // R9
  AST_WRAP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q < CNT_W'(1 << EVT_W)));                                          // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[20] && ovf) |=> irq_req);                                             // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req);                                             // R11
endmodule

bind qec_counter qec_checker #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_bits(ctl), .step_amt(step_amt), .counted(counted),
  .ovf(ovf), .cnt_wr(cnt_wr), .irq_clr(irq_clr), .cnt_q(cnt_q),
  .mon_pin(mon_pin), .irq_req(irq_req)
);

// File: tb/qec_counter_bench.sv
`timescale 1ns/100ps
module qec_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [3:0]  evt_count = 4'd0;
  logic [7:0]  evt_qual = 8'd0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        mon_pin;
  logic        irq_req;

  int total = 0;
  int bad = 0;

  // model state
  logic [31:0] m_ctl = 32'd0;
  logic [47:0] m_cnt = 48'd0;
  logic        m_prev = 1'b0;
  logic        m_pin = 1'b0;
  logic        m_irq = 1'b0;

  always #2 clk = ~clk;

  qec_counter u_qec_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_count(evt_count), .evt_qual(evt_qual), .priv_lvl(priv_lvl),
    .mon_pin(mon_pin), .irq_req(irq_req)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // condition per requirement R2..R5
  function automatic logic m_hit(logic [31:0] c, logic [3:0] n, logic [7:0] q, logic [1:0] p);
    logic g;
    g = c[22] && ((p == 2'd0) ? c[17] : c[16]) && ((c[15:8] == 8'd0) || ((c[15:8] & q) != 8'd0));
    if (c[31:24] == 8'd0) return g && (n != 4'd0);
    if (c[23]) return g && ({4'd0, n} < c[31:24]);
    return g && ({4'd0, n} >= c[31:24]);
  endfunction

  function automatic logic [3:0] m_amount(logic [31:0] c, logic [3:0] n, logic hit, logic prev);
    if (c[18]) return (hit && !prev) ? 4'd1 : 4'd0;
    if (!hit) return 4'd0;
    return (c[31:24] == 8'd0) ? n : 4'd1;
  endfunction

  function automatic string mode_tag(logic [31:0] c);
    if (!c[22]) return "R7";
    if (c[18])  return "R6";
    if (c[31:24] != 8'd0) return "R5";
    return "R4";
  endfunction

  task automatic read_all(output logic [47:0] cnt, output logic irqf);
    logic [31:0] lo;
    reg_wr = 1'b0;
    reg_addr = 2'd1; #0.2; lo = reg_rdata;
    reg_addr = 2'd2; #0.2; cnt = {reg_rdata[15:0], lo};
    reg_addr = 2'd3; #0.2; irqf = reg_rdata[0];
  endtask

  // one clock: drive at negedge, model, check after posedge
  task automatic step(logic wr, logic [1:0] a, logic [31:0] d, logic [3:0] n, logic [7:0] q, logic [1:0] p);
    logic hit, ovf, cwr, irqf;
    logic [3:0]  amt;
    logic [48:0] sum;
    logic [47:0] cnt;
    string tg;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    evt_count = n; evt_qual = q; priv_lvl = p;
    tg = mode_tag(m_ctl);
    hit = m_hit(m_ctl, n, q, p);
    amt = m_amount(m_ctl, n, hit, m_prev);
    m_prev = hit;
    cwr = wr && (a == 2'd1 || a == 2'd2);
    ovf = 1'b0;
    if (cwr) begin
      if (a == 2'd1) m_cnt[31:0] = d; else m_cnt[47:32] = d[15:0];
      m_pin = 1'b0;
    end else begin
      sum = {1'b0, m_cnt} + 49'(amt);
      ovf = sum[48];
      m_cnt = sum[47:0];
      m_pin = m_ctl[19] ? ovf : (amt != 4'd0);
    end
    if (m_ctl[20] && ovf) m_irq = 1'b1;
    else if (wr && a == 2'd3 && d[0]) m_irq = 1'b0;
    if (wr && a == 2'd0) m_ctl = d;
    @(posedge clk);
    #0.2;
    chk(m_ctl[19] ? "R9 pin" : "R8 pin", 64'(mon_pin), 64'(m_pin));
    read_all(cnt, irqf);
    chk({tg, " counter"}, 64'(cnt), 64'(m_cnt));
    chk("R11 irq flag", 64'(irqf), 64'(m_irq));
    chk("R11 irq pin", 64'(irq_req), 64'(m_irq));
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0, 2'd0, 32'd0, 4'd0, 8'd0, 2'd0);
  endtask

  initial begin
    #(4.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] c;
    logic f;
    void'($urandom(32'd20240917));
    #10 rst_n = 1'b1;
    @(posedge clk); #0.2;
    // R1 reset state
    read_all(c, f);
    chk("R1 counter", 64'(c), 64'd0);
    chk("R1 irq", 64'(f), 64'd0);
    chk("R1 pins", {62'd0, mon_pin, irq_req}, 64'd0);
    reg_addr = 2'd0; #0.2; chk("R1 ctl", 64'(reg_rdata), 64'd0);

    // R12 control readback including no-effect bits 7:0 and 21
    step(1'b1, 2'd0, 32'h0023_00A5 | 32'h0040_0000, 4'd0, 8'd0, 2'd0);
    reg_addr = 2'd0; #0.2; chk("R12 ctl readback", 64'(reg_rdata), 64'h0063_00A5);

    // R2 kernel-only: level 2 ignored, level 0 counts (threshold 0: full count, R4)
    step(1'b1, 2'd0, 32'h0062_00A5, 4'd0, 8'd0, 2'd0);
    step(1'b0, 2'd0, 0, 4'd5, 8'd0, 2'd2);
    step(1'b0, 2'd0, 0, 4'd7, 8'd0, 2'd0);
    read_all(c, f); chk("R2 kernel gating", 64'(c), 64'd7);

    // R3 mask 0x0C: qual 0x30 ignored, qual 0x04 counts
    step(1'b1, 2'd0, 32'h0043_0C00, 4'd0, 8'd0, 2'd0);
    step(1'b0, 2'd0, 0, 4'd3, 8'h30, 2'd1);
    step(1'b0, 2'd0, 0, 4'd3, 8'h04, 2'd1);
    read_all(c, f); chk("R3 mask gating", 64'(c), 64'd10);

    // R6 edge mode: run of 4 true then gap then 1 true => +2
    step(1'b1, 2'd0, 32'h0047_0000, 4'd0, 8'd0, 2'd0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 0, 4'd2, 8'd0, 2'd3);
    step(1'b0, 2'd0, 0, 4'd0, 8'd0, 2'd3);
    step(1'b0, 2'd0, 0, 4'd9, 8'd0, 2'd3);
    read_all(c, f); chk("R6 edge count", 64'(c), 64'd12);

    // R10/R9/R11: wrap in overflow-pin mode with irq
    step(1'b1, 2'd0, 32'h005B_0000, 4'd0, 8'd0, 2'd0);
    step(1'b1, 2'd2, 32'h0000_FFFF, 4'd0, 8'd0, 2'd0);
    step(1'b1, 2'd1, 32'hFFFF_FFFE, 4'd0, 8'd0, 2'd0);
    step(1'b0, 2'd0, 0, 4'd5, 8'd0, 2'd1);
    chk("R9 ovf pulse", 64'(mon_pin), 64'd1);
    read_all(c, f); chk("R10 wrap value", 64'(c), 64'd3);
    chk("R11 irq set", 64'(f), 64'd1);
    step(1'b0, 2'd0, 0, 4'd0, 8'd0, 2'd1);
    chk("R9 pulse one clock", 64'(mon_pin), 64'd0);
    step(1'b1, 2'd3, 32'd1, 4'd0, 8'd0, 2'd0);
    chk("R11 irq cleared", 64'(irq_req), 64'd0);

    // R7 disabled: nothing changes
    step(1'b1, 2'd0, 32'h0013_0000, 4'd0, 8'd0, 2'd0);
    for (int i = 0; i < 5; i++) step(1'b0, 2'd0, 0, 4'd15, 8'hFF, 2'd1);
    read_all(c, f); chk("R7 disabled hold", 64'(c), 64'd3);
    chk("R7 no pin", 64'(mon_pin), 64'd0);

    // random configurations
    for (int k = 0; k < 60; k++) begin
      logic [31:0] cw;
      cw = $urandom;
      cw[31:24] = ($urandom_range(0, 2) == 0) ? 8'd0 : 8'($urandom_range(1, 9));
      cw[22] = ($urandom_range(0, 5) != 0);
      cw[15:8] = ($urandom_range(0, 1) == 0) ? 8'd0 : cw[15:8];
      step(1'b1, 2'd0, cw, 4'($urandom), 8'($urandom), 2'($urandom));
      if ($urandom_range(0, 2) == 0) begin
        step(1'b1, 2'd2, 32'h0000_FFFF, 4'($urandom), 8'($urandom), 2'($urandom));
        step(1'b1, 2'd1, 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)), 4'($urandom), 8'($urandom), 2'($urandom));
      end
      for (int i = 0; i < 60; i++) begin
        int r;
        r = $urandom_range(0, 29);
        if (r == 0)      step(1'b1, 2'd3, 32'($urandom), 4'($urandom), 8'($urandom), 2'($urandom));
        else if (r == 1) step(1'b1, 2'd1, 32'hFFFF_FFF8, 4'($urandom), 8'($urandom), 2'($urandom));
        else             step(1'b0, 2'($urandom), 0, 4'($urandom), 8'($urandom), 2'($urandom));
      end
    end
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule